// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

This block is a single DMA channel. It copies a run of equal-width units between one fixed device address and a memory region that advances with each unit. All of its traffic goes through one request/response memory port. A transfer is described by four 32-bit words: device address, memory address, a size word holding a width code and a unit count, and a link word. The channel runs in one of two modes. In single mode the four words come straight from configuration inputs. In chained mode the channel is given only a link address, and it reads each descriptor from memory and then follows the links.

The link word carries two flags in its low bits. Bit 1 chooses between following the link and ending the chain. Bit 0 asks for a completion pulse. The channel reports a coarse status of idle, descriptor read, waiting or accessing. Writing the mode to off aborts the channel at any point.

The memory request channel is valid/ready. Once `mreq_valid_o` is high, the request holds steady until `mreq_ready_i` accepts it. Only reads get a response. The response channel is also valid/ready, and the bench's memory holds `mrsp_valid_i` until `mrsp_ready_o` takes it. The channel raises `mrsp_ready_o` while it waits for read data and also while idle, so that a response left over from an aborted read is drained and discarded.

Top module: `dmach_channel`

## Requirements
- R1: With `mode_i`=2 (single; 3 acts the same), a start pulse taken while idle loads the descriptor from the `cfg_*` inputs. The channel fetches nothing from memory and moves the units at once.
- R2: With `mode_i`=1 (chained), a start pulse taken while idle reads four words as 32-bit reads (`mreq_size_o`=2). It reads them in this order: device address at base+0x0, memory address at base+0x4, size at base+0x8, link at base+0xC. The base is `cfg_next_i` with its two low bits cleared.
- R3: Size-word bits 13:12 select the unit width: code 3 is 1 byte, code 2 is 2 bytes, code 0 is 4 bytes. Bits 11:0 hold the unit count. `mreq_size_o` gives log2 of the width. The memory address grows by the width after each unit and the device address stays fixed.
- R4: Each unit is one read followed by one write of the returned data. When `dir_i` is 1 at start, the read goes to memory and the write goes to the device. When `dir_i` is 0, the read goes to the device and the write goes to memory.
- R5: Width code 1 is rejected. A count above 0x3FF (1- and 2-byte widths) or above 0x7FF (4-byte width) is also rejected. A rejected descriptor sets `err_o`, moves no data and returns the channel to idle. Counts exactly at those limits are accepted.
- R6: `done_o` is high for exactly one cycle after each descriptor whose link bit 0 is set, and never after a descriptor whose bit 0 is clear.
- R7: In chained mode, link bit 1 set makes the channel fetch the next descriptor from the link address with bits 1:0 cleared. Bit 1 clear ends the chain and returns the channel to idle. In single mode the channel ignores bit 1.
- R8: `state_o` encodes 0 idle, 1 descriptor read, 2 waiting and 3 accessing. It reads 1 while a descriptor fetch is requested and 3 while a data read or write is requested. After reset it is 0, with `done_o`, `err_o` and `mreq_valid_o` low.
- R9: `mode_i`=0 while busy returns the channel to idle on the next cycle. After that no request is issued until a new start.
- R10: A start pulse while not idle is ignored and sets `err_o`. A start pulse while idle with `mode_i`=0 is ignored. A start that is accepted clears `err_o`.
- R11: Once a request is valid it stays valid, with address, write flag and data unchanged, until it is accepted. This holds unless the mode is switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | 0 off, 1 chained, 2 or 3 single |
| dir_i | input | 1 | 1 memory-to-device, 0 device-to-memory (taken at start) |
| start_i | input | 1 | Start pulse |
| cfg_dev_addr_i | input | AW | Single-mode device address |
| cfg_mem_addr_i | input | AW | Single-mode memory address |
| cfg_size_i | input | DW | Single-mode size word |
| cfg_next_i | input | AW | Link word (single) or chain base (chained) |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request ready |
| mreq_write_o | output | 1 | 1 write, 0 read |
| mreq_addr_o | output | AW | Request byte address |
| mreq_wdata_o | output | DW | Write data |
| mreq_size_o | output | 2 | log2 of access width in bytes |
| mrsp_valid_i | input | 1 | Read response valid |
| mrsp_ready_o | output | 1 | Read response ready |
| mrsp_data_i | input | DW | Read response data |
| state_o | output | 2 | Coarse channel status |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions check the rules that hold cycle by cycle: a pending request stays stable, switching the mode off forces idle on the next cycle, a start while busy sets the error flag, an idle channel issues no request and no done pulse, descriptor fetches are aligned word reads, and the completion signal is a single-cycle pulse. Other behaviour can only be shown by the bench's scenarios, where a transaction model predicts the exact sequence of addresses and data. That covers the order of descriptor words, the walk of addresses for each width and direction, the count limits at and just past their boundaries, a chain that stops at a bad descriptor, the number of done pulses per chain, and the silence of the port after an abort.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int SZ_WID_LSB = 12;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_CHAIN = 2'd1;

  typedef enum logic [1:0] {
    VIS_IDLE = 2'd0,
    VIS_DESC = 2'd1,
    VIS_WAIT = 2'd2,
    VIS_XFER = 2'd3
  } dmach_vis_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FREQ, PH_FWAIT, PH_CHECK,
    PH_RREQ, PH_RWAIT, PH_WREQ, PH_END
  } dmach_phase_e;

  function automatic dmach_vis_e vis_of(input dmach_phase_e p);
    case (p)
      PH_IDLE:                     return VIS_IDLE;
      PH_FREQ, PH_FWAIT:           return VIS_DESC;
      PH_RREQ, PH_WREQ:            return VIS_XFER;
      default:                     return VIS_WAIT;
    endcase
  endfunction
endpackage

// File: rtl/dmach_size_decode.sv
module dmach_size_decode
  import dmach_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter logic [CNT_W-1:0] LIM_NARROW = 'h3FF,
  parameter logic [CNT_W-1:0] LIM_WIDE   = 'h7FF
) (
  input  logic [SZ_WID_LSB+1:0] size_word_i,
  output logic [1:0]            unit_log2_o,
  output logic [CNT_W-1:0]      count_o,
  output logic                  bad_o
);
  always_comb begin
    count_o = size_word_i[CNT_W-1:0];
    case (size_word_i[SZ_WID_LSB+1:SZ_WID_LSB])
      2'd3: begin unit_log2_o = 2'd0; bad_o = (count_o > LIM_NARROW); end
      2'd2: begin unit_log2_o = 2'd1; bad_o = (count_o > LIM_NARROW); end
      2'd0: begin unit_log2_o = 2'd2; bad_o = (count_o > LIM_WIDE);   end
      default: begin unit_log2_o = 2'd0; bad_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/dmach_addr_walk.sv
module dmach_addr_walk #(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  input  logic [1:0]       unit_log2_i,
  output logic [AW-1:0]    addr_o,
  output logic             last_o
);
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      left_q <= count_i;
    end else if (step_i) begin
      addr_q <= addr_q + (AW'(1) << unit_log2_i);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/dmach_channel.sv
module dmach_channel
  import dmach_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 12,
  parameter logic [CNT_W-1:0] LIM_NARROW = 'h3FF,
  parameter logic [CNT_W-1:0] LIM_WIDE   = 'h7FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic          start_i,
  input  logic [AW-1:0] cfg_dev_addr_i,
  input  logic [AW-1:0] cfg_mem_addr_i,
  input  logic [DW-1:0] cfg_size_i,
  input  logic [AW-1:0] cfg_next_i,
  output logic          mreq_valid_o,
  input  logic          mreq_ready_i,
  output logic          mreq_write_o,
  output logic [AW-1:0] mreq_addr_o,
  output logic [DW-1:0] mreq_wdata_o,
  output logic [1:0]    mreq_size_o,
  input  logic          mrsp_valid_i,
  output logic          mrsp_ready_o,
  input  logic [DW-1:0] mrsp_data_i,
  output logic [1:0]    state_o,
  output logic          done_o,
  output logic          err_o
);
  dmach_phase_e  phase_q;
  logic          sg_q, dir_q, err_q;
  logic [AW-1:0] dev_q, mem_q, next_q, base_q;
  logic [DW-1:0] size_q, data_q;
  logic [1:0]    idx_q;

  logic [1:0]       unit_log2;
  logic [CNT_W-1:0] dec_count;
  logic             dec_bad;
  logic [AW-1:0]    walk_addr;
  logic             walk_last;
  logic             req_fire;

  dmach_size_decode #(.CNT_W(CNT_W), .LIM_NARROW(LIM_NARROW), .LIM_WIDE(LIM_WIDE)) u_dec (
    .size_word_i (size_q[SZ_WID_LSB+1:0]),
    .unit_log2_o (unit_log2),
    .count_o     (dec_count),
    .bad_o       (dec_bad)
  );

  dmach_addr_walk #(.AW(AW), .CNT_W(CNT_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (phase_q == PH_CHECK),
    .addr_i      (mem_q),
    .count_i     (dec_count),
    .step_i      (phase_q == PH_WREQ && mreq_ready_i),
    .unit_log2_i (unit_log2),
    .addr_o      (walk_addr),
    .last_o      (walk_last)
  );

  assign req_fire = mreq_valid_o && mreq_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sg_q    <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      dev_q   <= '0;
      mem_q   <= '0;
      next_q  <= '0;
      base_q  <= '0;
      size_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
    end else begin
      if (start_i && phase_q != PH_IDLE) err_q <= 1'b1;
      if (phase_q != PH_IDLE && mode_i == MODE_OFF) begin
        phase_q <= PH_IDLE;
      end else begin
        case (phase_q)
          PH_IDLE: if (start_i && mode_i != MODE_OFF) begin
            err_q <= 1'b0;
            dir_q <= dir_i;
            sg_q  <= (mode_i == MODE_CHAIN);
            if (mode_i == MODE_CHAIN) begin
              base_q  <= {cfg_next_i[AW-1:2], 2'b00};
              idx_q   <= '0;
              phase_q <= PH_FREQ;
            end else begin
              dev_q   <= cfg_dev_addr_i;
              mem_q   <= cfg_mem_addr_i;
              size_q  <= cfg_size_i;
              next_q  <= cfg_next_i;
              phase_q <= PH_CHECK;
            end
          end
          PH_FREQ: if (req_fire) phase_q <= PH_FWAIT;
          PH_FWAIT: if (mrsp_valid_i) begin
            case (idx_q)
              2'd0: dev_q  <= mrsp_data_i[AW-1:0];
              2'd1: mem_q  <= mrsp_data_i[AW-1:0];
              2'd2: size_q <= mrsp_data_i;
              default: next_q <= mrsp_data_i[AW-1:0];
            endcase
            idx_q   <= idx_q + 2'd1;
            phase_q <= (idx_q == 2'd3) ? PH_CHECK : PH_FREQ;
          end
          PH_CHECK: begin
            if (dec_bad) begin
              err_q   <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= (dec_count == '0) ? PH_END : PH_RREQ;
            end
          end
          PH_RREQ: if (req_fire) phase_q <= PH_RWAIT;
          PH_RWAIT: if (mrsp_valid_i) begin
            data_q  <= mrsp_data_i;
            phase_q <= PH_WREQ;
          end
          PH_WREQ: if (req_fire) phase_q <= walk_last ? PH_END : PH_RREQ;
          default: begin
            if (sg_q && next_q[1]) begin
              base_q  <= {next_q[AW-1:2], 2'b00};
              idx_q   <= '0;
              phase_q <= PH_FREQ;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    mreq_valid_o = (phase_q == PH_FREQ) || (phase_q == PH_RREQ) || (phase_q == PH_WREQ);
    mreq_write_o = (phase_q == PH_WREQ);
    mreq_wdata_o = data_q;
    mreq_size_o  = (phase_q == PH_FREQ) ? 2'd2 : unit_log2;
    case (phase_q)
      PH_FREQ: mreq_addr_o = base_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
      PH_RREQ: mreq_addr_o = dir_q ? walk_addr : dev_q;
      default: mreq_addr_o = dir_q ? dev_q : walk_addr;
    endcase
  end

  assign mrsp_ready_o = (phase_q == PH_IDLE) || (phase_q == PH_FWAIT) || (phase_q == PH_RWAIT);
  assign done_o       = (phase_q == PH_END) && next_q[0];
  assign err_o        = err_q;
  assign state_o      = vis_of(phase_q);
endmodule

// File: rtl/dmach_channel_chk.sv
module dmach_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          start_i,
  input logic          mreq_valid_o,
  input logic          mreq_ready_i,
  input logic          mreq_write_o,
  input logic [AW-1:0] mreq_addr_o,
  input logic [DW-1:0] mreq_wdata_o,
  input logic [1:0]    mreq_size_o,
  input logic [1:0]    state_o,
  input logic          done_o,
  input logic          err_o
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid_o && !mreq_ready_i && mode_i != 2'd0) |=>
      (mreq_valid_o && $stable(mreq_addr_o) && $stable(mreq_write_o) && $stable(mreq_wdata_o)));

  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |=> (state_o == 2'd0));

  p_busy_start_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_o != 2'd0) |=> err_o);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |-> (!mreq_valid_o && !done_o));

  p_fetch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && mreq_valid_o) |->
      (!mreq_write_o && mreq_size_o == 2'd2 && mreq_addr_o[1:0] == 2'b00));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_o == 2'd2));
endmodule

bind dmach_channel dmach_channel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .start_i      (start_i),
  .mreq_valid_o (mreq_valid_o),
  .mreq_ready_i (mreq_ready_i),
  .mreq_write_o (mreq_write_o),
  .mreq_addr_o  (mreq_addr_o),
  .mreq_wdata_o (mreq_wdata_o),
  .mreq_size_o  (mreq_size_o),
  .state_o      (state_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/dmach_channel_tb_top.sv
module dmach_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, dir, start;
  logic [1:0]  mode;
  logic [31:0] cfg_dev, cfg_mem, cfg_size, cfg_next;
  logic        mreq_valid, mreq_ready, mreq_write;
  logic [31:0] mreq_addr, mreq_wdata;
  logic [1:0]  mreq_size;
  logic        mrsp_valid, mrsp_ready;
  logic [31:0] mrsp_data;
  logic [1:0]  state;
  logic        done, err;

  dmach_channel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .start_i(start),
    .cfg_dev_addr_i(cfg_dev), .cfg_mem_addr_i(cfg_mem), .cfg_size_i(cfg_size),
    .cfg_next_i(cfg_next), .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready),
    .mreq_write_o(mreq_write), .mreq_addr_o(mreq_addr), .mreq_wdata_o(mreq_wdata),
    .mreq_size_o(mreq_size), .mrsp_valid_i(mrsp_valid), .mrsp_ready_o(mrsp_ready),
    .mrsp_data_i(mrsp_data), .state_o(state), .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] dmem [logic [31:0]];
  bit          q_fetch[$];
  bit          q_wr[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [1:0]  q_sz[$];
  int n_chk = 0, n_fail = 0, n_done = 0, cyc = 0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (dmem.exists(a)) return dmem[a];
    return (a * 32'd7) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit f, input bit w, input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz);
    q_fetch.push_back(f); q_wr.push_back(w); q_addr.push_back(a);
    q_data.push_back(d);  q_sz.push_back(sz);
  endtask

  task automatic clear_q();
    q_fetch.delete(); q_wr.delete(); q_addr.delete(); q_data.delete(); q_sz.delete();
  endtask

  task automatic add_fetch(input logic [31:0] base);
    for (int k = 0; k < 4; k++) push(1'b1, 1'b0, base + 32'(4*k), 32'h0, 2'd2);
  endtask

  task automatic add_xfer(input logic [31:0] dv, input logic [31:0] mm, input logic [31:0] sz, input bit d);
    logic [1:0] lg;
    logic [31:0] src, dst;
    int cnt;
    lg  = (sz[13:12] == 2'd3) ? 2'd0 : (sz[13:12] == 2'd2) ? 2'd1 : 2'd2;
    cnt = int'(sz[11:0]);
    for (int i = 0; i < cnt; i++) begin
      src = d ? mm + 32'(i << lg) : dv;
      dst = d ? dv : mm + 32'(i << lg);
      push(1'b0, 1'b0, src, 32'h0, lg);
      push(1'b0, 1'b1, dst, mem_rd(src), lg);
    end
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] dv, input logic [31:0] mm,
                          input logic [31:0] sz, input logic [31:0] nx);
    dmem[b] = dv; dmem[b+4] = mm; dmem[b+8] = sz; dmem[b+12] = nx;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (state != 2'd0) @(negedge clk);
  endtask

  task automatic run_single(input logic [31:0] dv, input logic [31:0] mm, input logic [31:0] sz,
                            input logic [31:0] nx, input bit d);
    mode = 2'd2; dir = d; cfg_dev = dv; cfg_mem = mm; cfg_size = sz; cfg_next = nx;
    n_done = 0;
    pulse_start();
    wait_idle();
  endtask

  task automatic scen_end(input string req, input int exp_done, input bit exp_err);
    chk(q_addr.size() == 0, {req, " pending requests"}, 32'(q_addr.size()), 0);
    chk(n_done == exp_done, {req, " done pulses"}, 32'(n_done), 32'(exp_done));
    chk(err == exp_err, {req, " error flag"}, {31'b0, err}, {31'b0, exp_err});
    chk(state == 2'd0, {req, " idle at end"}, {30'b0, state}, 0);
    clear_q();
  endtask

  // transaction-level reference: every cycle, each accepted request is compared
  bit rsp_take = 0, new_rsp = 0;
  logic [31:0] nd;
  initial begin
    mrsp_valid = 1'b0; mrsp_data = '0; mreq_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_take) begin mrsp_valid = 1'b0; rsp_take = 0; end
      if (new_rsp)  begin mrsp_valid = 1'b1; mrsp_data = nd; new_rsp = 0; end
      #1;
      mreq_ready = (mode != 2'd0) && (cyc % 3 != 1);
      cyc++;
      #1;
      if (done) n_done++;
      if (mrsp_valid && mrsp_ready) rsp_take = 1;
      if (mreq_valid && mreq_ready) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R9 unexpected request", mreq_addr, 32'h0);
        end else begin
          bit f, w; logic [31:0] a, dd; logic [1:0] sz;
          f = q_fetch.pop_front(); w = q_wr.pop_front(); a = q_addr.pop_front();
          dd = q_data.pop_front(); sz = q_sz.pop_front();
          chk(state == (f ? 2'd1 : 2'd3), "R8 state during request", {30'b0, state}, f ? 32'd1 : 32'd3);
          chk(mreq_write == w, f ? "R2 fetch is read" : "R4 read/write order", {31'b0, mreq_write}, {31'b0, w});
          chk(mreq_addr == a, f ? "R2 fetch address" : "R3 unit address", mreq_addr, a);
          chk(mreq_size == sz, "R3 access size", {30'b0, mreq_size}, {30'b0, sz});
          if (w) chk(mreq_wdata == dd, "R4 write data", mreq_wdata, dd);
        end
        if (!mreq_write) begin new_rsp = 1; nd = mem_rd(mreq_addr); end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; dir = 1'b0; start = 1'b0;
    cfg_dev = '0; cfg_mem = '0; cfg_size = '0; cfg_next = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == 2'd0, "R8 reset state", {30'b0, state}, 0);
    chk(!done, "R8 reset done", {31'b0, done}, 0);
    chk(!err, "R8 reset err", {31'b0, err}, 0);
    chk(!mreq_valid, "R8 reset request", {31'b0, mreq_valid}, 0);

    // R1 single, device to memory, 4-byte units, interrupt
    add_xfer(32'h4000_0010, 32'h2000_0000, 32'h0000_0003, 1'b0);
    run_single(32'h4000_0010, 32'h2000_0000, 32'h0000_0003, 32'h1, 1'b0);
    scen_end("R1", 1, 1'b0);

    // R4 single, memory to device, 1-byte units, no interrupt
    add_xfer(32'h4000_0020, 32'h2000_0101, 32'h0000_3002, 1'b1);
    run_single(32'h4000_0020, 32'h2000_0101, 32'h0000_3002, 32'h0, 1'b1);
    scen_end("R4", 0, 1'b0);

    // R7 single mode ignores the follow bit
    add_xfer(32'h4000_0030, 32'h2000_0200, 32'h0000_2001, 1'b0);
    run_single(32'h4000_0030, 32'h2000_0200, 32'h0000_2001, 32'h0000_5003, 1'b0);
    scen_end("R7", 1, 1'b0);

    // R2 chained, two descriptors, base low bits masked
    put_desc(32'h1000, 32'h4000_0040, 32'h2100_0000, 32'h0000_2002, 32'h0000_1102);
    put_desc(32'h1100, 32'h4000_0044, 32'h2100_0100, 32'h0000_0001, 32'h0000_0001);
    add_fetch(32'h1000); add_xfer(32'h4000_0040, 32'h2100_0000, 32'h0000_2002, 1'b0);
    add_fetch(32'h1100); add_xfer(32'h4000_0044, 32'h2100_0100, 32'h0000_0001, 1'b0);
    mode = 2'd1; dir = 1'b0; cfg_next = 32'h0000_1003; n_done = 0;
    pulse_start(); wait_idle();
    scen_end("R2", 1, 1'b0);

    // R6 three-link chain, interrupt on each, memory to device
    put_desc(32'h1200, 32'h4000_0050, 32'h2200_0000, 32'h0000_3003, 32'h0000_1303);
    put_desc(32'h1300, 32'h4000_0054, 32'h2200_0100, 32'h0000_2002, 32'h0000_1403);
    put_desc(32'h1400, 32'h4000_0058, 32'h2200_0200, 32'h0000_0002, 32'h0000_0001);
    add_fetch(32'h1200); add_xfer(32'h4000_0050, 32'h2200_0000, 32'h0000_3003, 1'b1);
    add_fetch(32'h1300); add_xfer(32'h4000_0054, 32'h2200_0100, 32'h0000_2002, 1'b1);
    add_fetch(32'h1400); add_xfer(32'h4000_0058, 32'h2200_0200, 32'h0000_0002, 1'b1);
    mode = 2'd1; dir = 1'b1; cfg_next = 32'h0000_1200; n_done = 0;
    pulse_start(); wait_idle();
    scen_end("R6", 3, 1'b0);

    // R5 width code 1 rejected
    run_single(32'h4000_0060, 32'h2300_0000, 32'h0000_1001, 32'h1, 1'b0);
    scen_end("R5", 0, 1'b1);

    // R5 count limits at and past the boundary
    add_xfer(32'h4000_0070, 32'h2400_0000, 32'h0000_33FF, 1'b0);
    run_single(32'h4000_0070, 32'h2400_0000, 32'h0000_33FF, 32'h0, 1'b0);
    scen_end("R5", 0, 1'b0);
    run_single(32'h4000_0070, 32'h2400_0000, 32'h0000_3400, 32'h1, 1'b0);
    scen_end("R5", 0, 1'b1);
    run_single(32'h4000_0070, 32'h2400_0000, 32'h0000_2400, 32'h1, 1'b0);
    scen_end("R5", 0, 1'b1);
    add_xfer(32'h4000_0074, 32'h2500_0000, 32'h0000_07FF, 1'b1);
    run_single(32'h4000_0074, 32'h2500_0000, 32'h0000_07FF, 32'h1, 1'b1);
    scen_end("R5", 1, 1'b0);
    run_single(32'h4000_0074, 32'h2500_0000, 32'h0000_0800, 32'h1, 1'b1);
    scen_end("R5", 0, 1'b1);

    // R5 chain stops at a bad second descriptor
    put_desc(32'h1500, 32'h4000_0080, 32'h2600_0000, 32'h0000_0001, 32'h0000_1603);
    put_desc(32'h1600, 32'h4000_0084, 32'h2600_0100, 32'h0000_1002, 32'h0000_0001);
    add_fetch(32'h1500); add_xfer(32'h4000_0080, 32'h2600_0000, 32'h0000_0001, 1'b0);
    add_fetch(32'h1600);
    mode = 2'd1; dir = 1'b0; cfg_next = 32'h0000_1500; n_done = 0;
    pulse_start(); wait_idle();
    scen_end("R5", 1, 1'b1);

    // R10 start while busy is ignored and flags an error
    add_xfer(32'h4000_0090, 32'h2700_0000, 32'h0000_0004, 1'b0);
    mode = 2'd2; dir = 1'b0; cfg_dev = 32'h4000_0090; cfg_mem = 32'h2700_0000;
    cfg_size = 32'h0000_0004; cfg_next = 32'h1; n_done = 0;
    pulse_start();
    repeat (3) @(negedge clk);
    cfg_mem = 32'h2800_0000; dir = 1'b1;
    pulse_start();
    chk(err == 1'b1, "R10 error after busy start", {31'b0, err}, 1);
    wait_idle();
    scen_end("R10", 1, 1'b1);

    // R9 mode off aborts, and no request follows
    add_xfer(32'h4000_00A0, 32'h2900_0000, 32'h0000_0028, 1'b0);
    mode = 2'd2; dir = 1'b0; cfg_dev = 32'h4000_00A0; cfg_mem = 32'h2900_0000;
    cfg_size = 32'h0000_0028; cfg_next = 32'h0; n_done = 0;
    pulse_start();
    repeat (10) @(negedge clk);
    mode = 2'd0;
    clear_q();
    @(negedge clk);
    chk(state == 2'd0, "R9 idle after mode off", {30'b0, state}, 0);
    mode = 2'd2;
    repeat (20) @(negedge clk);
    chk(state == 2'd0, "R9 stays idle without start", {30'b0, state}, 0);
    chk(err == 1'b0, "R9 abort sets no error", {31'b0, err}, 0);

    // R10 start with mode off is ignored
    mode = 2'd0;
    pulse_start();
    repeat (5) @(negedge clk);
    chk(state == 2'd0, "R10 start with mode off", {30'b0, state}, 0);
    chk(err == 1'b0, "R10 no error on ignored start", {31'b0, err}, 0);
    mode = 2'd2;
    repeat (10) @(negedge clk);
    chk(state == 2'd0, "R10 no late start", {30'b0, state}, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule